// File: doc/BRIEF.md
# Trace Message Queue with Overrun Recovery

This block is the shared message queue that sits between three trace message producers (error reports, watchpoint hits and data trace records) and the serial output stage. It has one write path into storage. When several producers request in the same cycle, a fixed priority picks one winner, and the losers are thrown away, not held back. Queued messages leave in arrival order through a valid/ready output port. Each message carries a two-bit kind tag and a payload.

When a message arrives and the queue is full, the queue enters a recovery mode. In this mode every arrival is discarded until the consumer has emptied the queue completely. The queue then inserts a single overrun message. Its payload is a small mask that records which lower-priority message kinds tried to get in during the recovery.

The data trace former is told about every data trace record that does not get in, through a one-cycle lost pulse. A sticky sync request also tells the former that its next record must carry a full synchronization address.

Top module: `trace_msg_queue`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0, `dtm_lost` is 0 and `dtm_sync_req` is 1.
- R2: At most one message enters per cycle. The order of preference is error, then watchpoint, then data trace. Any same-cycle request that does not win is discarded and never appears at the output.
- R3: When a data trace request is discarded (collision, overrun or recovery), `dtm_lost` is 1 for exactly the next cycle. It stays 0 after accepted requests.
- R4: Messages leave in the order they entered. `out_kind` is 0 for error, 1 for watchpoint, 2 for data trace and 3 for overrun. While `out_valid` is 1 and `out_ready` is 0, the kind and payload hold steady.
- R5: The queue holds `DEPTH` messages without loss. A winning request that arrives while `DEPTH` messages are stored starts an overrun and is discarded. This applies even if a pop happens in the same cycle.
- R6: During an overrun, every request from every producer is discarded until the queue has drained to empty.
- R7: When the queue becomes empty during an overrun, exactly one message of kind 3 is queued. In its payload, bit 0 is set if a watchpoint request arrived, and bit 1 is set if a data trace request arrived, in any cycle from the overflow cycle through the insertion cycle. All other payload bits are 0.
- R8: `dtm_sync_req` is set by reset, by any discarded data trace request and by entry into an overrun. It is cleared in the cycle after a data trace message is accepted.
- R9: The refused-type mask starts empty for every new overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| err_valid | input | 1 | Error message request |
| err_payload | input | PAY_W | Error message payload |
| wpt_valid | input | 1 | Watchpoint message request |
| wpt_payload | input | PAY_W | Watchpoint message payload |
| dtm_valid | input | 1 | Data trace message request |
| dtm_payload | input | PAY_W | Data trace message payload |
| out_valid | output | 1 | Head of queue is valid |
| out_ready | input | 1 | Consumer takes the head this cycle |
| out_kind | output | 2 | Kind of the head message |
| out_payload | output | PAY_W | Payload of the head message |
| dtm_lost | output | 1 | A data trace request was discarded last cycle |
| dtm_sync_req | output | 1 | Next data trace record must be a synchronization record |

## Verification
The bench sweeps all seven non-empty combinations of same-cycle requests. A wrong priority or a queued loser shows up as the wrong head kind or an extra entry. It also checks the lost pulse and the sync flag against every pattern. For all four refused-type masks, it fills the queue, forces an overrun with an error request, and injects refused traffic during the drain. A design that queued arrivals during recovery would show extra messages or missing payloads. A design with a sticky or wrong mask would produce a bad overrun payload. A design that inserted the overrun message early would place it ahead of the stored data. FIFO ordering is checked by running payloads through a full queue.

// File: rtl/tmq_pkg.sv
package tmq_pkg;
  typedef enum logic [1:0] {
    KIND_ERR = 2'd0,
    KIND_WPT = 2'd1,
    KIND_DTM = 2'd2,
    KIND_OVR = 2'd3
  } msg_kind_e;
  localparam int KIND_W = 2;
  localparam int MASK_W = 2;
endpackage

// File: rtl/tmq_arbiter.sv
module tmq_arbiter
  import tmq_pkg::*;
#(
  parameter int PAY_W = 32
) (
  input  logic             err_valid,
  input  logic [PAY_W-1:0] err_payload,
  input  logic             wpt_valid,
  input  logic [PAY_W-1:0] wpt_payload,
  input  logic             dtm_valid,
  input  logic [PAY_W-1:0] dtm_payload,
  output logic             win_valid,
  output msg_kind_e        win_kind,
  output logic [PAY_W-1:0] win_payload
);
  always_comb begin
    win_valid   = err_valid | wpt_valid | dtm_valid;
    win_kind    = KIND_DTM;
    win_payload = dtm_payload;
    if (err_valid) begin
      win_kind    = KIND_ERR;
      win_payload = err_payload;
    end else if (wpt_valid) begin
      win_kind    = KIND_WPT;
      win_payload = wpt_payload;
    end
  end
endmodule

// File: rtl/tmq_storage.sv
module tmq_storage #(
  parameter int DEPTH = 8,
  parameter int ENT_W = 34,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [ENT_W-1:0] push_data,
  input  logic             pop,
  output logic [ENT_W-1:0] head_data,
  output logic             full,
  output logic             empty,
  output logic [CNT_W-1:0] count
);
  logic [ENT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= bump(wr_ptr);
      if (pop)  rd_ptr <= bump(rd_ptr);
      count <= count + CNT_W'(push) - CNT_W'(pop);
    end
  end

  assign head_data = mem[rd_ptr];
  assign full      = (count == CNT_W'(DEPTH));
  assign empty     = (count == '0);
endmodule

// File: rtl/tmq_overrun_ctrl.sv
module tmq_overrun_ctrl
  import tmq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              win_valid,
  input  msg_kind_e         win_kind,
  input  logic              wpt_valid,
  input  logic              dtm_valid,
  input  logic              full,
  input  logic              empty,
  output logic              push,
  output logic              push_ovr,
  output logic [MASK_W-1:0] ovr_code,
  output logic              draining,
  output logic              dtm_lost,
  output logic              dtm_sync_req
);
  typedef enum logic {ST_RUN, ST_DRAIN} st_e;
  st_e               st_q, st_d;
  logic [MASK_W-1:0] mask_q, mask_d, arrivals;
  logic              dtm_accept, dtm_drop, enter_drain;

  assign arrivals = {dtm_valid, wpt_valid};
  assign draining = (st_q == ST_DRAIN);

  always_comb begin
    st_d        = st_q;
    mask_d      = mask_q;
    push        = 1'b0;
    push_ovr    = 1'b0;
    enter_drain = 1'b0;
    ovr_code    = mask_q | arrivals;
    if (st_q == ST_RUN) begin
      if (win_valid) begin
        if (full) begin
          st_d        = ST_DRAIN;
          mask_d      = arrivals;
          enter_drain = 1'b1;
        end else begin
          push = 1'b1;
        end
      end
    end else begin
      if (empty) begin
        push     = 1'b1;
        push_ovr = 1'b1;
        st_d     = ST_RUN;
        mask_d   = '0;
      end else begin
        mask_d = mask_q | arrivals;
      end
    end
  end

  assign dtm_accept = push && !push_ovr && (win_kind == KIND_DTM);
  assign dtm_drop   = dtm_valid && !dtm_accept;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q         <= ST_RUN;
      mask_q       <= '0;
      dtm_lost     <= 1'b0;
      dtm_sync_req <= 1'b1;
    end else begin
      st_q     <= st_d;
      mask_q   <= mask_d;
      dtm_lost <= dtm_drop;
      if (dtm_drop || enter_drain) dtm_sync_req <= 1'b1;
      else if (dtm_accept)         dtm_sync_req <= 1'b0;
    end
  end
endmodule

// File: rtl/trace_msg_queue.sv
module trace_msg_queue
  import tmq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PAY_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              err_valid,
  input  logic [PAY_W-1:0]  err_payload,
  input  logic              wpt_valid,
  input  logic [PAY_W-1:0]  wpt_payload,
  input  logic              dtm_valid,
  input  logic [PAY_W-1:0]  dtm_payload,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [KIND_W-1:0] out_kind,
  output logic [PAY_W-1:0]  out_payload,
  output logic              dtm_lost,
  output logic              dtm_sync_req
);
  localparam int ENT_W = KIND_W + PAY_W;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              win_valid;
  msg_kind_e         win_kind;
  logic [PAY_W-1:0]  win_payload;
  logic              push, push_ovr, draining, full, empty, pop;
  logic [MASK_W-1:0] ovr_code;
  logic [ENT_W-1:0]  push_data, head_data;
  logic [CNT_W-1:0]  fifo_count;

  tmq_arbiter #(.PAY_W(PAY_W)) u_arb (
    .err_valid(err_valid), .err_payload(err_payload),
    .wpt_valid(wpt_valid), .wpt_payload(wpt_payload),
    .dtm_valid(dtm_valid), .dtm_payload(dtm_payload),
    .win_valid(win_valid), .win_kind(win_kind), .win_payload(win_payload)
  );

  tmq_overrun_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .win_valid(win_valid), .win_kind(win_kind),
    .wpt_valid(wpt_valid), .dtm_valid(dtm_valid),
    .full(full), .empty(empty),
    .push(push), .push_ovr(push_ovr), .ovr_code(ovr_code),
    .draining(draining), .dtm_lost(dtm_lost), .dtm_sync_req(dtm_sync_req)
  );

  assign push_data = push_ovr ? {KIND_OVR, {(PAY_W-MASK_W){1'b0}}, ovr_code}
                              : {win_kind, win_payload};
  assign pop       = out_valid && out_ready;

  tmq_storage #(.DEPTH(DEPTH), .ENT_W(ENT_W)) u_store (
    .clk(clk), .rst(rst),
    .push(push), .push_data(push_data), .pop(pop),
    .head_data(head_data), .full(full), .empty(empty), .count(fifo_count)
  );

  assign out_valid   = !empty;
  assign out_kind    = head_data[ENT_W-1 -: KIND_W];
  assign out_payload = head_data[PAY_W-1:0];
endmodule

// File: rtl/trace_msg_queue_chk.sv
module trace_msg_queue_chk #(
  parameter int DEPTH = 8,
  parameter int PAY_W = 32,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             out_valid,
  input logic             out_ready,
  input logic [1:0]       out_kind,
  input logic [PAY_W-1:0] out_payload,
  input logic             dtm_valid,
  input logic             dtm_lost,
  input logic             dtm_sync_req,
  input logic             draining,
  input logic             empty,
  input logic             push,
  input logic [CNT_W-1:0] fifo_count
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && !dtm_lost && dtm_sync_req));
  // R3
  lost_cause_chk: assert property (@(posedge clk) disable iff (rst)
    dtm_lost |-> $past(dtm_valid));
  // R8
  lost_sets_sync_chk: assert property (@(posedge clk) disable iff (rst)
    dtm_lost |-> dtm_sync_req);
  // R4
  head_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_kind) && $stable(out_payload)));
  // R5
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CNT_W'(DEPTH));
  // R6
  drain_block_chk: assert property (@(posedge clk) disable iff (rst)
    (draining && !empty) |-> !push);
  // R7
  ovr_code_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_kind == 2'd3) |-> (out_payload[PAY_W-1:2] == '0));
endmodule

bind trace_msg_queue trace_msg_queue_chk #(.DEPTH(DEPTH), .PAY_W(PAY_W)) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ready(out_ready),
  .out_kind(out_kind), .out_payload(out_payload), .dtm_valid(dtm_valid),
  .dtm_lost(dtm_lost), .dtm_sync_req(dtm_sync_req), .draining(draining),
  .empty(empty), .push(push), .fifo_count(fifo_count)
);

// File: tb/trace_msg_queue_bench.sv
`timescale 1ns/1ps
module trace_msg_queue_bench;
  localparam int DEPTH = 4;
  localparam int PAY_W = 16;

  logic clk = 1'b0, rst = 1'b1;
  logic err_valid = 0, wpt_valid = 0, dtm_valid = 0, out_ready = 0;
  logic [PAY_W-1:0] err_payload = '0, wpt_payload = '0, dtm_payload = '0;
  logic out_valid, dtm_lost, dtm_sync_req;
  logic [1:0] out_kind;
  logic [PAY_W-1:0] out_payload;
  int checks = 0, fails = 0, cyc = 0;

  always #4 clk = ~clk;

  trace_msg_queue #(.DEPTH(DEPTH), .PAY_W(PAY_W)) u_trace_msg_queue (
    .clk(clk), .rst(rst),
    .err_valid(err_valid), .err_payload(err_payload),
    .wpt_valid(wpt_valid), .wpt_payload(wpt_payload),
    .dtm_valid(dtm_valid), .dtm_payload(dtm_payload),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_kind(out_kind), .out_payload(out_payload),
    .dtm_lost(dtm_lost), .dtm_sync_req(dtm_sync_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic e, input logic w, input logic d,
                      input logic [PAY_W-1:0] pe, input logic [PAY_W-1:0] pw,
                      input logic [PAY_W-1:0] pd);
    err_valid = e; wpt_valid = w; dtm_valid = d;
    err_payload = pe; wpt_payload = pw; dtm_payload = pd;
    @(negedge clk);
    err_valid = 0; wpt_valid = 0; dtm_valid = 0;
  endtask

  task automatic pop_expect(input string req, input logic [1:0] k, input logic [PAY_W-1:0] p);
    for (int i = 0; i < 20 && !out_valid; i++) @(negedge clk);
    chk(req, {31'd0, out_valid}, 32'd1);
    chk(req, {30'd0, out_kind}, {30'd0, k});
    chk(req, {16'd0, out_payload}, {16'd0, p});
    out_ready = 1;
    @(negedge clk);
    out_ready = 0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic exp_sync;
    logic [1:0] ek;
    logic [PAY_W-1:0] ep;
    repeat (3) @(negedge clk);
    // R1: state during reset
    chk("R1 valid", {31'd0, out_valid}, 0);
    chk("R1 sync", {31'd0, dtm_sync_req}, 1);
    rst = 0;
    @(negedge clk);
    chk("R1 valid after", {31'd0, out_valid}, 0);
    chk("R1 lost", {31'd0, dtm_lost}, 0);
    chk("R1 sync after", {31'd0, dtm_sync_req}, 1);

    // R2/R3/R8: sweep of all request combinations on an empty queue
    exp_sync = 1;
    for (int c = 0; c < 8; c++) begin
      send(c[2], c[1], c[0], PAY_W'(16'h0E00 + c), PAY_W'(16'h0A00 + c), PAY_W'(16'h0D00 + c));
      if (c[0]) exp_sync = (c[2] | c[1]) ? 1'b1 : 1'b0;
      chk("R3 lost pulse", {31'd0, dtm_lost}, {31'd0, c[0] & (c[2] | c[1])});
      chk("R8 sync", {31'd0, dtm_sync_req}, {31'd0, exp_sync});
      if (c == 0) begin
        chk("R2 no request", {31'd0, out_valid}, 0);
      end else begin
        ek = c[2] ? 2'd0 : c[1] ? 2'd1 : 2'd2;
        ep = c[2] ? PAY_W'(16'h0E00 + c) : c[1] ? PAY_W'(16'h0A00 + c) : PAY_W'(16'h0D00 + c);
        pop_expect("R2 winner", ek, ep);
        chk("R2 single entry", {31'd0, out_valid}, 0);
        chk("R3 pulse ends", {31'd0, dtm_lost}, 0);
      end
    end

    // R4/R5: fill to capacity with data trace, drain in order
    for (int i = 0; i < DEPTH; i++) send(0, 0, 1, '0, '0, PAY_W'(16'h0300 + i));
    chk("R8 cleared on accept", {31'd0, dtm_sync_req}, 0);
    for (int i = 0; i < DEPTH; i++) pop_expect("R4 order", 2'd2, PAY_W'(16'h0300 + i));
    chk("R5 no overrun at capacity", {31'd0, out_valid}, 0);

    // R5/R6/R7/R9: overrun with every refused-type mask
    for (int m = 0; m < 4; m++) begin
      for (int i = 0; i < DEPTH; i++) send(0, 1, 0, '0, PAY_W'(16'h0100 + 16*m + i), '0);
      send(1, 0, 0, PAY_W'(16'h0BAD), '0, '0);
      chk("R8 sync on overrun", {31'd0, dtm_sync_req}, 1);
      send(1, 0, 0, PAY_W'(16'h0BAE), '0, '0);
      if (m[0]) send(0, 1, 0, '0, PAY_W'(16'h0BAF), '0);
      if (m[1]) begin
        send(0, 0, 1, '0, '0, PAY_W'(16'h0BB0));
        chk("R3 lost in drain", {31'd0, dtm_lost}, 1);
      end
      for (int i = 0; i < DEPTH; i++) pop_expect("R6 stored data", 2'd1, PAY_W'(16'h0100 + 16*m + i));
      pop_expect("R7 R9 overrun code", 2'd3, PAY_W'(m));
      @(negedge clk);
      chk("R6 arrivals discarded", {31'd0, out_valid}, 0);
      send(0, 0, 1, '0, '0, PAY_W'(16'h0C00 + m));
      chk("R8 sync cleared", {31'd0, dtm_sync_req}, 0);
      pop_expect("R6 accepts after recovery", 2'd2, PAY_W'(16'h0C00 + m));
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule